// File: doc/BRIEF.md
# Protected System Clock Prescaler

This block holds the division setting for the system clock and produces the matching clock-enable from the master clock. Software reaches it through one 8-bit register on a simple register bus. A write strobe and a read strobe each qualify an address and the data. The 4-bit select field cannot be changed by a single stray write. Software must first write an arming pattern, which raises a change-enable flag. It must then write the new select value while that flag is still up. The flag drops by itself four master-clock cycles after it was raised.

The divider turns the select value into a single-cycle enable pulse, `sys_ce`, once per divided period. Logic in the system clock domain advances only on cycles where the enable is high. A change of division factor is taken up only at the end of the period that is running. No enable interval is ever shorter than either the old or the new period.

The control pins are plain. A write or read completes in the cycle its strobe is high, and there is no back-pressure. Read data is combinational. It is valid in the same cycle as the read strobe and reads zero when there is no read of this register. `def_sel` picks the select value that reset loads.

Top module: `clk_prescale_ctrl`

## Requirements
- R1: A read at the register address returns the change-enable flag in bit 7, zero in bits 6..4 whatever was written there, and the select field in bits 3..0. A read at any other address, or with no read strobe, returns 0x00.
- R2: Reset clears the change-enable flag and loads the select field with 3 when `def_sel` is 1, or with 0 when it is 0.
- R3: Only a write of exactly 0x80 sets the change-enable flag. A write with bit 7 high and any other bit nonzero leaves the flag as it was.
- R4: A flag set at clock edge k stays high through the cycle that ends at edge k+4 and is cleared by that edge. A select write sampled at edge k+4 is accepted, and one sampled at edge k+5 is ignored.
- R5: Writing 0x80 again while the flag is set neither clears the flag nor restarts its four-cycle countdown.
- R6: A write with bit 7 at zero, made while the flag is set, loads bits 3..0 into the select field and clears the flag. A write with bit 7 high made while the flag is set changes neither the select field nor the flag.
- R7: A write with bit 7 at zero made while the flag is clear, or any write to another address, leaves the register unchanged.
- R8: For select values 0 to 8, `sys_ce` pulses once every 2^select master-clock cycles (every cycle for select 0).
- R9: Select values 9 to 15 give the factor 256.
- R10: A new division factor takes effect only at a `sys_ce` pulse. The interval in which the change is written keeps the old length, and the following intervals have the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| def_sel | input | 1 | Reset default: 1 loads select 3, 0 loads select 0 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (6) | Register address; the block answers at REG_ADDR (0x26) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when not read |
| sys_ce | output | 1 | Divided system clock-enable, one cycle per period |

## Verification
The assertions check several rules on every cycle. Reserved read bits are always zero. The flag never stays up longer than its window and can rise only after an exact arming write. The select field changes only through a guarded write, and the divider's active limit changes only on an enable pulse. Other behaviour can only be shown by the bench scenarios. These cover the exact window edges (edge k+4 accepted, edge k+5 refused), re-arming without extension, the period produced for each select value including the clamped ones, and the length of the interval that spans a factor change.

// File: rtl/clkp_pkg.sv
package clkp_pkg;
  localparam int DATA_W    = 8;
  localparam int SEL_W     = 4;
  localparam int MAX_LOG2  = 8;
  localparam int CNT_W     = MAX_LOG2;
  localparam int FLAG_BIT  = 7;
  localparam logic [DATA_W-1:0] ARM_PATTERN = 8'h80;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // Terminal count for a select value: 2^min(sel,MAX_LOG2) - 1
  function automatic cnt_t sel_to_limit(input sel_t sel);
    logic [SEL_W-1:0] shamt;
    logic [CNT_W:0]   full;
    shamt = (sel > sel_t'(MAX_LOG2)) ? sel_t'(MAX_LOG2) : sel;
    full  = ({{CNT_W{1'b0}}, 1'b1} << shamt) - 1'b1;
    return full[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/clkp_unlock.sv
module clkp_unlock
  import clkp_pkg::*;
#(
  parameter int TIMEOUT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_t              rst_sel,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              flag_o,
  output sel_t              sel_o
);
  localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  logic          flag_q;
  logic [TW-1:0] tcnt_q;
  sel_t          sel_q;

  logic load_sel, arm;
  assign load_sel = flag_q && wr_hit && !wdata[FLAG_BIT];
  assign arm      = !flag_q && wr_hit && (wdata == ARM_PATTERN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      tcnt_q <= '0;
      sel_q  <= rst_sel;
    end else if (load_sel) begin
      sel_q  <= wdata[SEL_W-1:0];
      flag_q <= 1'b0;
      tcnt_q <= '0;
    end else if (flag_q) begin
      // window runs on regardless of further writes
      if (tcnt_q == LAST) begin
        flag_q <= 1'b0;
        tcnt_q <= '0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end else if (arm) begin
      flag_q <= 1'b1;
      tcnt_q <= '0;
    end
  end

  assign flag_o = flag_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/clkp_divider.sv
module clkp_divider
  import clkp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sel_t rst_sel,
  input  sel_t sel_i,
  output logic ce_o
);
  cnt_t cnt_q;
  cnt_t act_lim_q;
  logic at_end;

  assign at_end = (cnt_q == act_lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_lim_q <= sel_to_limit(rst_sel);
    end else if (at_end) begin
      cnt_q     <= '0;
      act_lim_q <= sel_to_limit(sel_i);   // switch only at period boundary
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ce_o = at_end;
endmodule

// File: rtl/clk_prescale_ctrl.sv
module clk_prescale_ctrl
  import clkp_pkg::*;
#(
  parameter int                ADDR_W      = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 6'h26,
  parameter int                TIMEOUT     = 4,
  parameter int                ALT_DEFAULT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              def_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_ce
);
  logic addr_hit, wr_hit, chg_en;
  sel_t sel_q, rst_sel;

  assign addr_hit = (bus_addr == REG_ADDR);
  assign wr_hit   = bus_wr && addr_hit;
  assign rst_sel  = def_sel ? sel_t'(ALT_DEFAULT) : sel_t'(0);

  clkp_unlock #(.TIMEOUT(TIMEOUT)) u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sel(rst_sel),
    .wr_hit (wr_hit),
    .wdata  (bus_wdata),
    .flag_o (chg_en),
    .sel_o  (sel_q)
  );

  clkp_divider u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sel(rst_sel),
    .sel_i  (sel_q),
    .ce_o   (sys_ce)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && addr_hit) begin
      bus_rdata[FLAG_BIT]  = chg_en;
      bus_rdata[SEL_W-1:0] = sel_q;
    end
  end
endmodule

// File: rtl/clkp_checker.sv
module clkp_checker
  import clkp_pkg::*;
#(
  parameter int TIMEOUT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              flag,
  input sel_t              sel,
  input cnt_t              act_lim,
  input logic              ce
);
  int unsigned fcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fcnt <= 0;
    else if (flag) fcnt <= fcnt + 1;
    else           fcnt <= 0;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6:4] == 3'b000);

  assert_arm_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit && wdata == ARM_PATTERN));

  assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> fcnt < TIMEOUT);

  assert_sel_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> $past(flag && hit && !wdata[FLAG_BIT]));

  assert_switch_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_lim) |-> $past(ce));
endmodule

bind clk_prescale_ctrl clkp_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .hit    (wr_hit),
  .wdata  (bus_wdata),
  .rdata  (bus_rdata),
  .flag   (chg_en),
  .sel    (sel_q),
  .act_lim(u_div.act_lim_q),
  .ce     (sys_ce)
);

// File: tb/clk_prescale_ctrl_tb_top.sv
module clk_prescale_ctrl_tb_top;
  localparam logic [5:0] RA = 6'h26;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       def_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sys_ce;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  clk_prescale_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .def_sel(def_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_ce(sys_ce)
  );

  // enable-pulse monitor
  int cyc = 0, last_ce = 0, last_gap = 0, n_pulses = 0;
  bit have = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) have = 0;
    else if (sys_ce) begin
      if (have) last_gap = cyc - last_ce;
      last_ce = cyc;
      have = 1;
      n_pulses++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic d);
    rst_n = 0; def_sel = d; bus_wr = 0; bus_rd = 0;
    idle(3);
    rst_n = 1;
  endtask

  // called at a negedge; the write is sampled at the next posedge
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    bus_rd = 0;
    @(negedge clk);
  endtask

  task automatic set_sel(input logic [7:0] v);
    wr(RA, 8'h80);
    wr(RA, v);
  endtask

  task automatic expect_reg(input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(RA, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic settled_gap(output int g);
    int p;
    p = n_pulses;
    while (n_pulses < p + 3) @(negedge clk);
    g = last_gap;
  endtask

  task automatic t_reset();
    int g;
    do_reset(1'b1);
    expect_reg(8'h03, "R2 default 3");
    settled_gap(g);
    check(g == 8, "R2 reset period 8", g, 8);
    do_reset(1'b0);
    expect_reg(8'h00, "R2 default 0");
    settled_gap(g);
    check(g == 1, "R2 reset period 1", g, 1);
  endtask

  task automatic t_layout();
    logic [7:0] v;
    set_sel(8'h75);
    expect_reg(8'h05, "R1 reserved bits ignored");
    wr(RA, 8'h80);
    expect_reg(8'h85, "R1 flag in bit 7");
    idle(5);
    expect_reg(8'h05, "R1 flag cleared");
    rd(6'h27, v);
    check(v == 8'h00, "R1 other address reads zero", v, 0);
  endtask

  task automatic t_arm_pattern();
    wr(RA, 8'h81);
    expect_reg(8'h05, "R3 0x81 does not arm");
    wr(RA, 8'h82);
    wr(RA, 8'h07);
    expect_reg(8'h05, "R3 0x82 then select refused");
    wr(RA, 8'h03);
    expect_reg(8'h05, "R7 unarmed write ignored");
    wr(6'h25, 8'h80);
    wr(RA, 8'h07);
    expect_reg(8'h05, "R7 arm at other address ignored");
    wr(RA, 8'h80);
    wr(6'h25, 8'h07);
    idle(5);
    expect_reg(8'h05, "R7 select to other address ignored");
  endtask

  task automatic t_timeout();
    wr(RA, 8'h80);
    idle(3);
    wr(RA, 8'h06);
    expect_reg(8'h06, "R4 write at edge k+4 accepted");
    wr(RA, 8'h80);
    idle(4);
    wr(RA, 8'h02);
    expect_reg(8'h06, "R4 write at edge k+5 refused");
  endtask

  task automatic t_rearm();
    wr(RA, 8'h80);
    wr(RA, 8'h80);
    wr(RA, 8'h04);
    expect_reg(8'h04, "R5 rearm does not clear");
    wr(RA, 8'h80);
    idle(1);
    wr(RA, 8'h80);
    idle(2);
    wr(RA, 8'h01);
    expect_reg(8'h04, "R5 rearm does not extend");
    wr(RA, 8'h80);
    wr(RA, 8'h81);
    expect_reg(8'h84, "R6 bit7-high write keeps flag and select");
    idle(4);
    set_sel(8'h09);
    expect_reg(8'h09, "R6 guarded write loads and clears flag");
  endtask

  task automatic t_periods();
    int g;
    for (int s = 0; s <= 8; s++) begin
      set_sel(8'(s));
      settled_gap(g);
      check(g == (1 << s), $sformatf("R8 select %0d period", s), g, 1 << s);
    end
    for (int s = 9; s <= 15; s += 3) begin
      set_sel(8'(s));
      settled_gap(g);
      check(g == 256, $sformatf("R9 select %0d clamped", s), g, 256);
    end
  endtask

  task automatic t_switch();
    int g, p;
    set_sel(8'h08);
    settled_gap(g);
    p = n_pulses;
    idle(10);
    set_sel(8'h00);
    while (n_pulses < p + 1) @(negedge clk);
    check(last_gap == 256, "R10 old period kept", last_gap, 256);
    while (n_pulses < p + 3) @(negedge clk);
    check(last_gap == 1, "R10 new period after boundary", last_gap, 1);
    set_sel(8'h02);
    settled_gap(g);
    p = n_pulses;
    set_sel(8'h06);
    while (n_pulses < p + 1) @(negedge clk);
    check(last_gap == 4, "R10 short old period kept", last_gap, 4);
    while (n_pulses < p + 2) @(negedge clk);
    check(last_gap == 64, "R10 long period after boundary", last_gap, 64);
  endtask

  initial begin
    idle(1);
    t_reset();
    t_layout();
    t_arm_pattern();
    t_timeout();
    t_rearm();
    t_periods();
    t_switch();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule